// File: doc/BRIEF.md
# Driver Diagnostic Sequencer with Interrupt

This block runs one diagnostic pass over two switched load drivers and a thermal monitor. A start bit held in the control register opens a qualification window that lasts a fixed number of microsecond ticks. During that window each raw comparator flag must stay high on every clock. At the end of the window the flags that held throughout, filtered by the mode the pass was started in, are written into an 8-bit result register.

Normal mode reports overcurrent. Test mode reports open load and short to supply. Over-temperature is reported in both modes. When the new result differs from the previous one in any bit, an active-low interrupt is raised and a one-cycle request asks the control register to set its start bit again. A host read of the result register in the waiting state releases the interrupt and asks for the start bit to be cleared. The serial link and the analog comparators sit outside this block.

The controller has four states. `ST_IDLE` accepts a start. `ST_QUAL` runs the window. `ST_COMMIT` writes the result. `ST_DONE` waits for the host read. The transitions are:

- accept: from `ST_IDLE` to `ST_QUAL`, when the start bit is set and the start is legal.
- reject: stays in `ST_IDLE`, when a normal-mode start arrives while a driver is disabled.
- expire: from `ST_QUAL` to `ST_COMMIT`.
- store: from `ST_COMMIT` to `ST_DONE`.
- release: from `ST_DONE` to `ST_IDLE`, on a read.

Top module: `drvdiag_seq`

## Requirements
- R1: In the idle state, a set start bit begins a pass when `test_mode_i` is 1, or when both `drv1_en_i` and `drv2_en_i` are 1. The mode is captured at that start, and test mode needs no driver enabled.
- R2: In the idle state, a set start bit with `test_mode_i` 0 and a driver disabled is rejected. `start_clr_o` is high for that cycle, no pass runs, and the register keeps its contents.
- R3: Result layout. Bit 7 is 1 when the pass ran in test mode. Bits 6 and 3 are overcurrent of driver 1 and driver 2. Bits 5 and 2 are open load of driver 1 and driver 2. Bits 4 and 1 are short to supply of driver 1 and driver 2. Bit 0 is over-temperature. `fault_raw_i[6:0]` uses the same bit positions.
- R4: In a normal pass, only bits 6, 3 and 0 may be set. In a test pass, only bits 5, 4, 2, 1 and 0 may be set. All other fault bits read 0.
- R5: A fault bit is recorded only if its flag is high on every clock from the start of the pass until `QUAL_US` ticks have elapsed. A drop of a single cycle, or a flag that rises after the start, discards that fault.
- R6: The register is written two cycles after the window expires. `irq_n_o` goes low on that same edge if any of the 8 bits differs from the previous contents, and stays high otherwise.
- R7: `start_set_o` is high for one cycle, the cycle before a changing write.
- R8: A read in the waiting state raises `start_clr_o` in that cycle, returns `irq_n_o` high on the next edge, and returns the controller to idle.
- R9: A read during the qualification window has no effect. The register keeps its previous contents, the start bit is not cleared, and the pass completes normally.
- R10: After reset, the register is 0, `irq_n_o` is high, and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_bit_i | input | 1 | Start-diagnostics bit from the control register |
| test_mode_i | input | 1 | Test-mode bit from the control register |
| drv1_en_i | input | 1 | Driver 1 enable bit |
| drv2_en_i | input | 1 | Driver 2 enable bit |
| fault_raw_i | input | 7 | Raw comparator flags, same positions as result bits 6..0 |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| diag_rd_i | input | 1 | Result-register read strobe |
| diag_o | output | 8 | Result register |
| irq_n_o | output | 1 | Interrupt, active low (open-drain at the pad) |
| start_set_o | output | 1 | Request to set the start bit |
| start_clr_o | output | 1 | Request to clear the start bit |

## Verification
A wrong state or window count shows up at the ports as a result written too early or too late. It also shows up as an interrupt with no read able to release it, or as a clear request in the wrong cycle. A reference model compared on every clock catches each of these on the first cycle the outputs diverge.

A qualification counter that fails to restart on a dropped flag only shows at the end of the window. That is up to `QUAL_US` ticks later, as a spurious result bit and a spurious interrupt. Mode-masking errors likewise show as a wrong bit at the write edge.

// File: rtl/drvdiag_pkg.sv
package drvdiag_pkg;
    localparam int FLT_N  = 7;
    localparam int DIAG_W = FLT_N + 1;

    // Fault positions that each mode is allowed to report
    localparam logic [FLT_N-1:0] NORMAL_MASK = 7'b100_1001;
    localparam logic [FLT_N-1:0] TEST_MASK   = 7'b011_0111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUAL,
        ST_COMMIT,
        ST_DONE
    } dg_state_e;
endpackage

// File: rtl/drvdiag_qual.sv
module drvdiag_qual #(
    parameter int QUAL_US = 100,
    parameter int CNT_W   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    input  logic flag_i,
    output logic held_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_US);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr_i) begin
            run_cnt <= '0;
        end else if (en_i) begin
            if (!flag_i) begin
                run_cnt <= '0;
            end else if (tick_i && run_cnt != LIMIT) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign held_o = (run_cnt == LIMIT);

    // R5
    flag_break_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !flag_i) |=> (run_cnt == '0));

    // R5
    qual_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LIMIT);
endmodule

// File: rtl/drvdiag_window.sv
module drvdiag_window #(
    parameter int QUAL_US = 100,
    parameter int CNT_W   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_US);

    logic [CNT_W-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (clr_i) begin
            win_cnt <= '0;
        end else if (en_i && tick_i && win_cnt != LIMIT) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assign expired_o = (win_cnt == LIMIT);

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= LIMIT);
endmodule

// File: rtl/drvdiag_ctrl.sv
module drvdiag_ctrl
    import drvdiag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              test_mode_i,
    input  logic              drv1_en_i,
    input  logic              drv2_en_i,
    input  logic              rd_i,
    input  logic              expired_i,
    input  logic [FLT_N-1:0]  held_i,
    output logic              accept_o,
    output logic              run_o,
    output logic              start_set_o,
    output logic              start_clr_o,
    output logic              irq_n_o,
    output logic [DIAG_W-1:0] diag_o
);
    dg_state_e         state_q, state_d;
    logic              mode_q;
    logic              irq_q;
    logic [DIAG_W-1:0] diag_q;
    logic [DIAG_W-1:0] result;
    logic              legal_start;
    logic              differs;

    assign legal_start = test_mode_i | (drv1_en_i & drv2_en_i);

    always_comb begin
        result  = {mode_q, held_i & (mode_q ? TEST_MASK : NORMAL_MASK)};
        differs = (result != diag_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, reject, expire, store, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i && legal_start) state_d = ST_QUAL;
            ST_QUAL:   if (expired_i) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   if (rd_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        accept_o    = 1'b0;
        run_o       = 1'b0;
        start_set_o = 1'b0;
        start_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_o    = start_i & legal_start;
                start_clr_o = start_i & ~legal_start;
            end
            ST_QUAL:   run_o = 1'b1;
            ST_COMMIT: start_set_o = differs;
            ST_DONE:   start_clr_o = rd_i;
            default: begin
                accept_o = 1'b0;
            end
        endcase
    end

    // Result register, captured mode and interrupt latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            diag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (accept_o) begin
                mode_q <= test_mode_i;
            end
            if (state_q == ST_COMMIT) begin
                diag_q <= result;
                if (differs) begin
                    irq_q <= 1'b1;
                end
            end
            if (state_q == ST_DONE && rd_i) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq_n_o = ~irq_q;
    assign diag_o  = diag_q;

    // R2
    no_dual_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_set_o, start_clr_o}));

    // R2
    reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !test_mode_i && !(drv1_en_i && drv2_en_i))
        |=> (state_q == ST_IDLE && $stable(diag_q)));

    // R4
    normal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_q[7] |-> (diag_q[5:4] == 2'b00 && diag_q[2:1] == 2'b00));

    // R4
    test_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_q[7] |-> (!diag_q[6] && !diag_q[3]));

    // R6
    write_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(diag_q) |-> ($past(state_q) == ST_COMMIT));

    // R7
    set_then_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_set_o |=> !irq_n_o);

    // R8
    read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && rd_i) |=> (irq_n_o && state_q == ST_IDLE));

    // R9
    early_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL) |=> $stable(diag_q));
endmodule

// File: rtl/drvdiag_seq.sv
module drvdiag_seq
    import drvdiag_pkg::*;
#(
    parameter int QUAL_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_bit_i,
    input  logic              test_mode_i,
    input  logic              drv1_en_i,
    input  logic              drv2_en_i,
    input  logic [FLT_N-1:0]  fault_raw_i,
    input  logic              us_tick_i,
    input  logic              diag_rd_i,
    output logic [DIAG_W-1:0] diag_o,
    output logic              irq_n_o,
    output logic              start_set_o,
    output logic              start_clr_o
);
    localparam int CNT_W = $clog2(QUAL_US + 1);

    logic             accept;
    logic             run;
    logic             expired;
    logic             count_en;
    logic [FLT_N-1:0] held;

    assign count_en = run & ~expired;

    drvdiag_window #(
        .QUAL_US (QUAL_US),
        .CNT_W   (CNT_W)
    ) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .en_i      (run),
        .tick_i    (us_tick_i),
        .expired_o (expired)
    );

    generate
        for (genvar g = 0; g < FLT_N; g++) begin : g_qual
            drvdiag_qual #(
                .QUAL_US (QUAL_US),
                .CNT_W   (CNT_W)
            ) qual_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (accept),
                .en_i   (count_en),
                .tick_i (us_tick_i),
                .flag_i (fault_raw_i[g]),
                .held_o (held[g])
            );
        end
    endgenerate

    drvdiag_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_bit_i),
        .test_mode_i (test_mode_i),
        .drv1_en_i   (drv1_en_i),
        .drv2_en_i   (drv2_en_i),
        .rd_i        (diag_rd_i),
        .expired_i   (expired),
        .held_i      (held),
        .accept_o    (accept),
        .run_o       (run),
        .start_set_o (start_set_o),
        .start_clr_o (start_clr_o),
        .irq_n_o     (irq_n_o),
        .diag_o      (diag_o)
    );
endmodule

// File: tb/drvdiag_seq_tb.sv
module drvdiag_seq_tb_top;
    localparam int Q   = 100;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sb = 1'b0;
    logic       tm = 1'b0;
    logic       d1 = 1'b1;
    logic       d2 = 1'b1;
    logic       tick = 1'b0;
    logic       rd = 1'b0;
    logic       host_set = 1'b0;
    logic [6:0] flt = 7'h00;
    logic [7:0] diag;
    logic       irq_n;
    logic       sset;
    logic       sclr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    drvdiag_seq #(.QUAL_US(Q)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_bit_i (sb),
        .test_mode_i (tm),
        .drv1_en_i   (d1),
        .drv2_en_i   (d2),
        .fault_raw_i (flt),
        .us_tick_i   (tick),
        .diag_rd_i   (rd),
        .diag_o      (diag),
        .irq_n_o     (irq_n),
        .start_set_o (sset),
        .start_clr_o (sclr)
    );

    // Control-register start bit, as seen by the block
    always @(posedge clk) begin
        if (!rst_n)              sb <= 1'b0;
        else if (sclr)           sb <= 1'b0;
        else if (host_set || sset) sb <= 1'b1;
    end

    // Microsecond tick every DIV cycles
    int tph = 0;
    always @(posedge clk) begin
        #1;
        tick = (tph == DIV - 1);
        tph  = (tph + 1) % DIV;
    end

    // Behavioural reference model
    int ms = 0;
    int mwin = 0;
    int mcnt[7];
    int mmode = 0;
    int mdiag = 0;
    bit mirq = 1'b0;

    function automatic bit reportable(int k, int mode);
        if (k == 0) return 1'b1;
        if (mode != 0) return (k != 6 && k != 3);
        return (k == 6 || k == 3);
    endfunction

    function automatic int predicted();
        int c = mmode * 128;
        for (int k = 0; k < 7; k++)
            if (mcnt[k] == Q && reportable(k, mmode)) c = c + (1 << k);
        return c;
    endfunction

    always @(posedge clk) begin
        int c;
        if (!rst_n) begin
            ms = 0; mwin = 0; mmode = 0; mdiag = 0; mirq = 1'b0;
            for (int k = 0; k < 7; k++) mcnt[k] = 0;
        end else begin
            case (ms)
                0: if (sb && (tm || (d1 && d2))) begin
                    ms = 1; mmode = int'(tm); mwin = 0;
                    for (int k = 0; k < 7; k++) mcnt[k] = 0;
                end
                1: if (mwin == Q) ms = 2;
                   else begin
                       if (tick) mwin = mwin + 1;
                       for (int k = 0; k < 7; k++) begin
                           if (!flt[k]) mcnt[k] = 0;
                           else if (tick && mcnt[k] < Q) mcnt[k] = mcnt[k] + 1;
                       end
                   end
                2: begin
                    c = predicted();
                    if (c != mdiag) mirq = 1'b1;
                    mdiag = c;
                    ms = 3;
                end
                default: if (rd) begin mirq = 1'b0; ms = 0; end
            endcase
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3", "diag_o", int'(diag), mdiag);
            check("R6", "irq_n_o", int'(irq_n), int'(!mirq));
            check("R7", "start_set_o", int'(sset), int'(ms == 2 && predicted() != mdiag));
            check("R2/R8", "start_clr_o", int'(sclr),
                  int'((ms == 0 && sb && !(tm || (d1 && d2))) || (ms == 3 && rd)));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host_start();
        @(posedge clk); #1 host_set = 1'b1;
        @(posedge clk); #1 host_set = 1'b0;
    endtask

    task automatic host_read();
        @(posedge clk); #1 rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
    endtask

    task automatic probe(string req, string what, int act, int exp);
        @(negedge clk);
        check(req, what, act, exp);
    endtask

    localparam int RUN = Q * DIV + 12;

    initial begin
        cyc(4);
        probe("R10", "reset diag_o", int'(diag), 0);
        probe("R10", "reset irq_n_o", int'(irq_n), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        cyc(2);
        probe("R10", "idle irq_n_o after release", int'(irq_n), 1);

        // Normal pass: overcurrent and over-temp recorded, open load masked
        tm = 1'b0; flt = 7'b110_0001;
        host_start(); cyc(RUN);
        probe("R4", "normal result", int'(diag), 8'h41);
        probe("R6", "irq after change", int'(irq_n), 0);
        host_read(); cyc(1);
        probe("R8", "irq released by read", int'(irq_n), 1);
        probe("R8", "start bit cleared", int'(sb), 0);

        // Test pass: short drv1 and open load drv2, overcurrent masked
        tm = 1'b1; flt = 7'b001_1100;
        host_start(); cyc(RUN);
        probe("R3", "test result layout", int'(diag), 8'h94);
        probe("R6", "irq after test change", int'(irq_n), 0);
        host_read(); cyc(1);

        // Early read during qualification
        tm = 1'b0; flt = 7'h00;
        host_start(); cyc(60);
        host_read(); cyc(1);
        probe("R9", "early read keeps result", int'(diag), 8'h94);
        probe("R9", "early read keeps start bit", int'(sb), 1);
        cyc(RUN);
        probe("R9", "pass completes after early read", int'(diag), 8'h00);
        probe("R6", "irq on clear-to-zero change", int'(irq_n), 0);
        host_read(); cyc(1);

        // One-cycle break in a flag
        flt = 7'b000_1000;
        host_start(); cyc(100);
        flt = 7'h00; cyc(1);
        flt = 7'b000_1000;
        cyc(RUN);
        probe("R5", "broken flag discarded", int'(diag), 8'h00);
        probe("R6", "no irq without change", int'(irq_n), 1);
        host_read(); cyc(1);

        // Flag rising after the start
        flt = 7'h00;
        host_start(); cyc(20);
        flt = 7'b000_0001;
        cyc(RUN);
        probe("R5", "late flag discarded", int'(diag), 8'h00);
        host_read(); cyc(1);

        // Rejected normal start with a driver disabled
        d2 = 1'b0; flt = 7'b100_0000;
        host_start(); cyc(3);
        probe("R2", "rejected start clears bit", int'(sb), 0);
        cyc(RUN);
        probe("R2", "no pass after reject", int'(diag), 8'h00);
        probe("R2", "no irq after reject", int'(irq_n), 1);

        // Test pass with drivers off: only the mode bit changes
        tm = 1'b1; d1 = 1'b0; flt = 7'h00;
        host_start(); cyc(RUN);
        probe("R1", "test start with drivers off", int'(diag), 8'h80);
        probe("R6", "irq on mode-bit change", int'(irq_n), 0);
        host_read(); cyc(1);

        // All flags in each mode
        d1 = 1'b1; d2 = 1'b1; tm = 1'b0; flt = 7'h7F;
        host_start(); cyc(RUN);
        probe("R4", "normal all flags", int'(diag), 8'h49);
        host_read(); cyc(1);
        tm = 1'b1;
        host_start(); cyc(RUN);
        probe("R4", "test all flags", int'(diag), 8'hB7);
        host_read(); cyc(2);
        probe("R8", "idle after final read", int'(irq_n), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            finished = 1'b1;
            $display("FAIL watchdog R1 run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule